// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits on a simple 32-bit register bus and manages an array of one-time-programmable fuses laid out as 8 banks of 256 rows, 8 bits per row. Software selects a fuse with two address registers, then either blows that single bit (a program operation) or reads back the physical contents of the selected row (an explicit sense). Both operations run for a fixed number of cycles with `busy` raised. A done flag in the status register marks completion.

Beside the physical fuses, every row has a shadow copy that is reached through a row window in the address map. Writing the window overrides the shadow. Reading it returns the shadow. A completed program reloads the shadow of that row from the fuse value. Three static per-bank protection inputs guard the three paths. A protected access is refused and flagged in the error register. Programming also requires a key value in a dedicated register. Status and error flags are write-one-to-clear and each has a mask feeding one interrupt line.

The fuses are modelled as flops that clear only on reset. Register map (byte offsets): 0x00 status, 0x04 status mask, 0x08 error, 0x0C error mask, 0x10 control, 0x14 upper address, 0x18 lower address, 0x1C sense data, 0x20 and 0x24 read as zero, 0x28 program key. The row window starts at 0x800.

Top module: `fuse_array_ctrl`

## Requirements
- R1: After reset every register, the sense data and every shadow row read 0, and `busy` and `irq` are 0.
- R2: Writing 1 to control bit 0 while idle, with the key register at 0xAA and the bank not write-protected, holds `busy` high for exactly 16 cycles. It then sets status bit 1 and ORs the addressed bit into the fuse row. The shadow of that row is reloaded with the new fuse value.
- R3: A program request while the key register is not 0xAA sets error bit 7 on the next cycle, never raises `busy` and leaves the fuse row unchanged.
- R4: A program request on a bank whose `wr_prot` bit is 1 (key correct) sets error bit 6, never raises `busy` and leaves the fuse row unchanged.
- R5: Writing 1 to control bit 3 while idle holds `busy` for exactly 4 cycles, then loads the physical row into the sense-data register (offset 0x1C, low 8 bits) and sets status bit 0.
- R6: Control-bit-0 or control-bit-3 writes while `busy` is high are ignored. The running operation keeps its length and the fuse location latched at its start, and no second operation follows.
- R7: A window write to a bank with `ovr_prot` clear replaces the low 8 bits of that row's shadow, and a window read returns it. The physical fuse row is unaffected.
- R8: A window write to a bank whose `ovr_prot` bit is 1 sets error bit 5 and leaves the shadow unchanged.
- R9: A window read of a bank whose `rd_prot` bit is 1 returns 0 and sets error bit 4.
- R10: Writing 1 to a status bit (1:0) or error bit (7:1) clears it; writing 0 leaves it.
- R11: `irq` is 1 exactly when a set status bit has its mask bit (offset 0x04) set or a set error bit has its mask bit (offset 0x0C) set.
- R12: The upper address register holds the bank in bits 5:3 and row bits 7:5 in bits 2:0. The lower address register holds row bits 4:0 in bits 7:3 and the bit index in bits 2:0. Window row r of bank b is at byte 0x800 + b·0x400 + r·4.
- R13: Programming never clears a fuse bit; a second program of the same row keeps the bits blown earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 14 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| busy | output | 1 | A program or sense operation is running |
| irq | output | 1 | Masked status or error flag present |
| rd_prot | input | 8 | Per-bank read protection for the row window |
| ovr_prot | input | 8 | Per-bank override (window write) protection |
| wr_prot | input | 8 | Per-bank program protection |

## Verification
The bench restarts a program while one is running, changing the bit index in between. A design that re-armed the counter or read the live address would stretch `busy` past 16 cycles or blow two bits. A rejected program (wrong key, protected bank) is followed by a sense of the same row. A design that flagged the error but still blew the fuse, or started a busy period, would show it. Override and read protection are checked by reading the shadow back after a refused write. A design that wrote through anyway, or leaked data on a protected read, would return the wrong byte. A second program of a row shows whether an earlier bit is lost by a plain write instead of an OR. The highest bank and row check the address split.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    // Array geometry
    localparam int FZ_BANKS  = 8;
    localparam int FZ_ROWS   = 256;
    localparam int FZ_BITS   = 8;
    localparam int BANK_W    = $clog2(FZ_BANKS);
    localparam int ROW_W     = $clog2(FZ_ROWS);
    localparam int BITI_W    = $clog2(FZ_BITS);
    localparam int CELL_W    = BANK_W + ROW_W;

    // Bus geometry
    localparam int BUS_AW    = 14;
    localparam int BUS_DW    = 32;
    localparam logic [BUS_AW-1:0] WIN_BASE = 14'h0800;
    localparam int WIN_SPAN  = FZ_BANKS * FZ_ROWS * 4;

    // Register offsets (low byte of the address)
    localparam logic [7:0] OFS_STAT  = 8'h00;
    localparam logic [7:0] OFS_STATM = 8'h04;
    localparam logic [7:0] OFS_ERR   = 8'h08;
    localparam logic [7:0] OFS_EMASK = 8'h0C;
    localparam logic [7:0] OFS_CTRL  = 8'h10;
    localparam logic [7:0] OFS_ADRH  = 8'h14;
    localparam logic [7:0] OFS_ADRL  = 8'h18;
    localparam logic [7:0] OFS_SDAT  = 8'h1C;
    localparam logic [7:0] OFS_KEY   = 8'h28;

    localparam logic [7:0] PRG_KEY   = 8'hAA;

    // Bit positions
    localparam int ST_BUSY   = 7;
    localparam int ST_PDONE  = 1;
    localparam int ST_SDONE  = 0;
    localparam int ER_PRG    = 7;
    localparam int ER_WPROT  = 6;
    localparam int ER_OPROT  = 5;
    localparam int ER_RPROT  = 4;
    localparam int CT_PRG    = 0;
    localparam int CT_SNS    = 3;
    localparam logic [7:0] CT_KEEP = 8'hF6;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_SENSE = 2'd2
    } fuse_op_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [BITI_W-1:0] bidx;
    } fuse_loc_t;

    typedef struct packed {
        logic prg;
        logic wprot;
        logic oprot;
        logic rprot;
    } err_ev_t;

    function automatic fuse_loc_t loc_from_regs(input logic [5:0] adr_hi,
                                                input logic [7:0] adr_lo);
        fuse_loc_t l;
        l.bank = adr_hi[5:3];
        l.row  = {adr_hi[2:0], adr_lo[7:3]};
        l.bidx = adr_lo[2:0];
        return l;
    endfunction

    function automatic logic [CELL_W-1:0] cell_of(input logic [BANK_W-1:0] b,
                                                  input logic [ROW_W-1:0] r);
        return {b, r};
    endfunction

endpackage

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_pkg::*;
#(
    parameter int PRG_CYCLES = 16,
    parameter int SNS_CYCLES = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_prg,
    input  logic      req_sns,
    input  fuse_loc_t loc_in,
    output logic      busy,
    output fuse_loc_t loc_q,
    output logic      done_prg,
    output logic      done_sns
);
    localparam int MAXC = (PRG_CYCLES > SNS_CYCLES) ? PRG_CYCLES : SNS_CYCLES;
    localparam int CW   = $clog2(MAXC) + 1;

    fuse_op_e        op_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= OP_IDLE;
            cnt_q <= '0;
            loc_q <= '0;
        end else if (op_q == OP_IDLE) begin
            if (req_prg) begin
                op_q  <= OP_PROG;
                cnt_q <= CW'(PRG_CYCLES - 1);
                loc_q <= loc_in;
            end else if (req_sns) begin
                op_q  <= OP_SENSE;
                cnt_q <= CW'(SNS_CYCLES - 1);
                loc_q <= loc_in;
            end
        end else if (cnt_q == '0) begin
            op_q <= OP_IDLE;
        end else begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign busy     = (op_q != OP_IDLE);
    assign done_prg = (op_q == OP_PROG)  && (cnt_q == '0);
    assign done_sns = (op_q == OP_SENSE) && (cnt_q == '0);

    // R2: a running operation counts down by one every cycle
    a_r2_countdown: assert property (@(posedge clk) disable iff (rst)
        busy && cnt_q != '0 |=> busy && cnt_q == $past(cnt_q) - CW'(1));

    // R6: requests during an operation change neither its kind nor its target
    a_r6_hold_target: assert property (@(posedge clk) disable iff (rst)
        busy && cnt_q != '0 |=> $stable(loc_q) && $stable(op_q));

    // R5: an idle sense request starts a sense of the programmed length
    a_r5_sense_start: assert property (@(posedge clk) disable iff (rst)
        !busy && req_sns && !req_prg |=> op_q == OP_SENSE && cnt_q == CW'(SNS_CYCLES - 1));

endmodule

// File: rtl/fuse_store.sv
module fuse_store
    import fuse_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  fuse_loc_t          tgt,
    input  logic               ovr_we,
    input  logic [BANK_W-1:0]  win_bank,
    input  logic [ROW_W-1:0]   win_row,
    input  logic [FZ_BITS-1:0] ovr_data,
    output logic [FZ_BITS-1:0] tgt_fuse,
    output logic [FZ_BITS-1:0] win_val
);
    localparam int NCELL = FZ_BANKS * FZ_ROWS;

    logic [FZ_BITS-1:0] fuse_q   [NCELL];
    logic [FZ_BITS-1:0] shadow_q [NCELL];

    logic [CELL_W-1:0]  tgt_cell;
    logic [CELL_W-1:0]  win_cell;
    logic [FZ_BITS-1:0] blown;

    assign tgt_cell = cell_of(tgt.bank, tgt.row);
    assign win_cell = cell_of(win_bank, win_row);
    assign tgt_fuse = fuse_q[tgt_cell];
    assign win_val  = shadow_q[win_cell];
    assign blown    = tgt_fuse | (FZ_BITS'(1) << tgt.bidx);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCELL; i++) begin
                fuse_q[i]   <= '0;
                shadow_q[i] <= '0;
            end
        end else begin
            if (ovr_we) begin
                shadow_q[win_cell] <= ovr_data;
            end
            // a completing program has the last word on its own row
            if (commit) begin
                fuse_q[tgt_cell]   <= blown;
                shadow_q[tgt_cell] <= blown;
            end
        end
    end

    // R13: the programmed row keeps every earlier bit and gains the target bit
    a_r13_or_only: assert property (@(posedge clk) disable iff (rst)
        commit |=> ((tgt_fuse & $past(tgt_fuse)) == $past(tgt_fuse))
                   && tgt_fuse[$past(tgt.bidx)]);

    // R2: the shadow of the programmed row follows the fuse value
    a_r2_shadow_reload: assert property (@(posedge clk) disable iff (rst)
        commit && !ovr_we |=> fuse_q[$past(tgt_cell)] == shadow_q[$past(tgt_cell)]);

endmodule

// File: rtl/fuse_regs.sv
module fuse_regs
    import fuse_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [BUS_DW-1:0]  bus_wdata,
    output logic [BUS_DW-1:0]  bus_rdata,
    output logic               irq,
    input  logic [FZ_BANKS-1:0] rd_prot,
    input  logic [FZ_BANKS-1:0] ovr_prot,
    input  logic [FZ_BANKS-1:0] wr_prot,
    input  logic               busy,
    input  logic               done_prg,
    input  logic               done_sns,
    output logic               req_prg,
    output logic               req_sns,
    output fuse_loc_t          loc_req,
    input  logic [FZ_BITS-1:0] tgt_fuse,
    input  logic [FZ_BITS-1:0] win_val,
    output logic               ovr_we,
    output logic [BANK_W-1:0]  win_bank,
    output logic [ROW_W-1:0]   win_row,
    output logic [FZ_BITS-1:0] ovr_data
);
    // ---------------- state ----------------
    logic [1:0] stat_q;     // {prog done, sense done}
    logic [1:0] statm_q;
    logic [7:1] err_q;
    logic [7:1] emask_q;
    logic [7:0] ctrl_q;
    logic [5:0] adrh_q;
    logic [7:0] adrl_q;
    logic [7:0] sdat_q;
    logic [7:0] key_q;

    // ---------------- decode ----------------
    logic              reg_sel, win_sel;
    logic [BUS_AW-1:0] win_off;
    logic [7:0]        ofs;

    assign ofs     = bus_addr[7:0];
    assign reg_sel = (bus_addr[BUS_AW-1:8] == '0);
    assign win_off = bus_addr - WIN_BASE;
    assign win_sel = (bus_addr >= WIN_BASE) && (32'(win_off) < WIN_SPAN);
    assign win_bank = win_off[ROW_W+2 +: BANK_W];
    assign win_row  = win_off[2 +: ROW_W];

    logic unused_ok;
    assign unused_ok = ^{bus_wdata[BUS_DW-1:8], win_off[1:0], win_off[BUS_AW-1:ROW_W+2+BANK_W]};

    function automatic logic wr_at(input logic [7:0] o);
        return bus_wr && reg_sel && (ofs == o);
    endfunction

    logic win_wr, win_rd;
    assign win_wr = bus_wr && win_sel;
    assign win_rd = bus_rd && win_sel;

    // ---------------- command checks ----------------
    logic    prg_try, sns_try, key_ok, wp_hit;
    err_ev_t ev;

    assign loc_req = loc_from_regs(adrh_q, adrl_q);
    assign key_ok  = (key_q == PRG_KEY);
    assign wp_hit  = wr_prot[loc_req.bank];
    assign prg_try = wr_at(OFS_CTRL) && bus_wdata[CT_PRG] && !busy;
    assign sns_try = wr_at(OFS_CTRL) && bus_wdata[CT_SNS] && !busy && !bus_wdata[CT_PRG];

    assign req_prg = prg_try && key_ok && !wp_hit;
    assign req_sns = sns_try;

    assign ev.prg   = prg_try && !key_ok;
    assign ev.wprot = prg_try && key_ok && wp_hit;
    assign ev.oprot = win_wr && ovr_prot[win_bank];
    assign ev.rprot = win_rd && rd_prot[win_bank];

    assign ovr_we   = win_wr && !ovr_prot[win_bank];
    assign ovr_data = bus_wdata[FZ_BITS-1:0];

    // ---------------- flag update ----------------
    logic [1:0] stat_set, stat_clr;
    logic [7:1] err_set,  err_clr;

    assign stat_set = {done_prg, done_sns};
    assign stat_clr = wr_at(OFS_STAT) ? bus_wdata[1:0] : 2'b00;
    assign err_clr  = wr_at(OFS_ERR)  ? bus_wdata[7:1] : 7'b0;

    always_comb begin
        err_set = '0;
        err_set[ER_PRG]   = ev.prg;
        err_set[ER_WPROT] = ev.wprot;
        err_set[ER_OPROT] = ev.oprot;
        err_set[ER_RPROT] = ev.rprot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            statm_q <= '0;
            err_q   <= '0;
            emask_q <= '0;
            ctrl_q  <= '0;
            adrh_q  <= '0;
            adrl_q  <= '0;
            sdat_q  <= '0;
            key_q   <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
            err_q  <= (err_q  & ~err_clr)  | err_set;
            if (wr_at(OFS_STATM)) statm_q <= bus_wdata[1:0];
            if (wr_at(OFS_EMASK)) emask_q <= bus_wdata[7:1];
            if (wr_at(OFS_CTRL))  ctrl_q  <= bus_wdata[7:0] & CT_KEEP;
            if (wr_at(OFS_ADRH))  adrh_q  <= bus_wdata[5:0];
            if (wr_at(OFS_ADRL))  adrl_q  <= bus_wdata[7:0];
            if (wr_at(OFS_KEY))   key_q   <= bus_wdata[7:0];
            if (done_sns)         sdat_q  <= tgt_fuse;
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (win_sel) begin
            if (!rd_prot[win_bank]) bus_rdata[FZ_BITS-1:0] = win_val;
        end else if (reg_sel) begin
            unique case (ofs)
                OFS_STAT: begin
                    bus_rdata[ST_BUSY]  = busy;
                    bus_rdata[ST_PDONE] = stat_q[1];
                    bus_rdata[ST_SDONE] = stat_q[0];
                end
                OFS_STATM: bus_rdata[1:0] = statm_q;
                OFS_ERR:   bus_rdata[7:1] = err_q;
                OFS_EMASK: bus_rdata[7:1] = emask_q;
                OFS_CTRL:  bus_rdata[7:0] = ctrl_q;
                OFS_ADRH:  bus_rdata[5:0] = adrh_q;
                OFS_ADRL:  bus_rdata[7:0] = adrl_q;
                OFS_SDAT:  bus_rdata[7:0] = sdat_q;
                OFS_KEY:   bus_rdata[7:0] = key_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq = (|(stat_q & statm_q)) || (|(err_q & emask_q));

    // R3: a program without the key raises the program error and starts nothing
    a_r3_bad_key: assert property (@(posedge clk) disable iff (rst)
        prg_try && !key_ok |=> err_q[ER_PRG] && !busy);

    // R8: a refused override write is flagged
    a_r8_ovr_flag: assert property (@(posedge clk) disable iff (rst)
        win_wr && ovr_prot[win_bank] |=> err_q[ER_OPROT]);

    // R10: a one written to sense-done clears it unless a sense completes
    a_r10_w1c_sense: assert property (@(posedge clk) disable iff (rst)
        wr_at(OFS_STAT) && bus_wdata[ST_SDONE] && !done_sns |=> !stat_q[0]);

    // R9: a protected window read never exposes shadow data
    a_r9_no_leak: assert property (@(posedge clk) disable iff (rst)
        win_sel && rd_prot[win_bank] |-> bus_rdata == '0);

endmodule

// File: rtl/fuse_array_ctrl.sv
module fuse_array_ctrl
    import fuse_pkg::*;
#(
    parameter int PRG_CYCLES = 16,
    parameter int SNS_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [13:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        busy,
    output logic        irq,
    input  logic [7:0]  rd_prot,
    input  logic [7:0]  ovr_prot,
    input  logic [7:0]  wr_prot
);
    logic               req_prg, req_sns, done_prg, done_sns, ovr_we;
    fuse_loc_t          loc_req, loc_q;
    logic [FZ_BITS-1:0] tgt_fuse, win_val, ovr_data;
    logic [BANK_W-1:0]  win_bank;
    logic [ROW_W-1:0]   win_row;

    fuse_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .rd_prot   (rd_prot),
        .ovr_prot  (ovr_prot),
        .wr_prot   (wr_prot),
        .busy      (busy),
        .done_prg  (done_prg),
        .done_sns  (done_sns),
        .req_prg   (req_prg),
        .req_sns   (req_sns),
        .loc_req   (loc_req),
        .tgt_fuse  (tgt_fuse),
        .win_val   (win_val),
        .ovr_we    (ovr_we),
        .win_bank  (win_bank),
        .win_row   (win_row),
        .ovr_data  (ovr_data)
    );

    fuse_seq #(
        .PRG_CYCLES (PRG_CYCLES),
        .SNS_CYCLES (SNS_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_prg  (req_prg),
        .req_sns  (req_sns),
        .loc_in   (loc_req),
        .busy     (busy),
        .loc_q    (loc_q),
        .done_prg (done_prg),
        .done_sns (done_sns)
    );

    fuse_store u_store (
        .clk      (clk),
        .rst      (rst),
        .commit   (done_prg),
        .tgt      (loc_q),
        .ovr_we   (ovr_we),
        .win_bank (win_bank),
        .win_row  (win_row),
        .ovr_data (ovr_data),
        .tgt_fuse (tgt_fuse),
        .win_val  (win_val)
    );

    // R1: nothing is running or signalled in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !busy && !irq);

endmodule

// File: tb/sim_fuse_array_ctrl.sv
module sim_fuse_array_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        busy, irq;
    logic [7:0]  rd_prot = '0;
    logic [7:0]  ovr_prot = '0;
    logic [7:0]  wr_prot = '0;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [13:0] A_STAT = 14'h00, A_STATM = 14'h04, A_ERR = 14'h08,
                            A_EMASK = 14'h0C, A_CTRL = 14'h10, A_ADRH = 14'h14,
                            A_ADRL = 14'h18, A_SDAT = 14'h1C, A_KEY = 14'h28;

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    fuse_array_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .irq(irq),
        .rd_prot(rd_prot), .ovr_prot(ovr_prot), .wr_prot(wr_prot)
    );

    function automatic logic [13:0] win(input int b, input int r);
        return 14'(32'h800 + b * 32'h400 + r * 4);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: pushes the expected read value, the monitor compares it
    task automatic rd(input logic [13:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // monitor
    initial forever begin
        @(negedge clk);
        #1;
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL monitor: read with no expectation, actual=%h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        int t0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_STAT, 32'h0, "R1 status");
        rd(A_ERR, 32'h0, "R1 error");
        rd(A_SDAT, 32'h0, "R1 sense data");
        rd(win(0, 0), 32'h0, "R1 shadow");

        // R2 / R12 program bank 3 row 90 bit 5
        wr(A_KEY, 32'hAA);
        wr(A_ADRH, 32'h1A);
        wr(A_ADRL, 32'hD5);
        rd(A_ADRH, 32'h1A, "R12 upper address");
        rd(A_ADRL, 32'hD5, "R12 lower address");
        wr(A_CTRL, 32'h01);
        busy_len(n);
        chk("R2 program length", n, 16);
        rd(A_STAT, 32'h02, "R2 program done");
        rd(win(3, 90), 32'h20, "R2 shadow reload");

        // R13 second bit in the same row
        wr(A_ADRL, 32'hD0);
        wr(A_CTRL, 32'h01);
        busy_len(n);
        chk("R13 program length", n, 16);
        rd(win(3, 90), 32'h21, "R13 earlier bit kept");

        // R5 sense
        wr(A_CTRL, 32'h08);
        busy_len(n);
        chk("R5 sense length", n, 4);
        rd(A_SDAT, 32'h21, "R5 sense data");
        rd(A_STAT, 32'h03, "R5 sense done");
        chk("R11 unmasked irq", {31'b0, irq}, 32'h0);

        // R10 write-one-to-clear
        wr(A_STAT, 32'h01);
        rd(A_STAT, 32'h02, "R10 clear sense done");
        wr(A_STAT, 32'h00);
        rd(A_STAT, 32'h02, "R10 zero write keeps");
        wr(A_STAT, 32'h02);
        rd(A_STAT, 32'h00, "R10 clear program done");

        // R11 status interrupt
        wr(A_STATM, 32'h01);
        wr(A_CTRL, 32'h08);
        busy_len(n);
        chk("R11 status irq", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h01);
        chk("R11 irq cleared", {31'b0, irq}, 32'h0);

        // R3 wrong key
        wr(A_KEY, 32'h55);
        wr(A_ADRL, 32'hD2);
        wr(A_CTRL, 32'h01);
        chk("R3 no busy", {31'b0, busy}, 32'h0);
        rd(A_ERR, 32'h80, "R3 program error");
        wr(A_CTRL, 32'h08);
        busy_len(n);
        rd(A_SDAT, 32'h21, "R3 fuse unchanged");
        wr(A_STAT, 32'h03);
        wr(A_EMASK, 32'h80);
        chk("R11 error irq", {31'b0, irq}, 32'h1);
        wr(A_ERR, 32'h80);
        rd(A_ERR, 32'h00, "R10 error cleared");
        chk("R11 error irq cleared", {31'b0, irq}, 32'h0);

        // R4 write-protected bank 2
        wr_prot = 8'h04;
        wr(A_KEY, 32'hAA);
        wr(A_ADRH, 32'h12);
        wr(A_CTRL, 32'h01);
        chk("R4 no busy", {31'b0, busy}, 32'h0);
        rd(A_ERR, 32'h40, "R4 write-protect error");
        wr(A_CTRL, 32'h08);
        busy_len(n);
        rd(A_SDAT, 32'h00, "R4 fuse unchanged");
        wr(A_ERR, 32'h40);
        wr(A_STAT, 32'h03);
        wr_prot = 8'h00;

        // R6 starts during busy ignored
        wr(A_ADRH, 32'h00);
        wr(A_ADRL, 32'h07);
        wr(A_CTRL, 32'h01);
        t0 = cyc;
        wr(A_ADRL, 32'h06);
        wr(A_CTRL, 32'h01);
        wr(A_CTRL, 32'h08);
        while (busy === 1'b1 && cyc - t0 < 1000) @(negedge clk);
        chk("R6 length unchanged", cyc - t0, 16);
        repeat (20) @(negedge clk);
        chk("R6 no second op", {31'b0, busy}, 32'h0);
        rd(A_STAT, 32'h02, "R6 no sense done");
        rd(win(0, 0), 32'h80, "R6 latched bit");
        wr(A_STAT, 32'h03);

        // R7 override
        wr(win(1, 5), 32'h3C);
        rd(win(1, 5), 32'h3C, "R7 shadow written");
        wr(A_ADRH, 32'h08);
        wr(A_ADRL, 32'h28);
        wr(A_CTRL, 32'h08);
        busy_len(n);
        rd(A_SDAT, 32'h00, "R7 fuse untouched");
        wr(A_STAT, 32'h03);

        // R8 override-protected
        ovr_prot = 8'h02;
        wr(win(1, 5), 32'hFF);
        rd(A_ERR, 32'h20, "R8 override error");
        rd(win(1, 5), 32'h3C, "R8 shadow kept");

        // R9 read-protected
        rd_prot = 8'h02;
        rd(win(1, 5), 32'h00, "R9 protected read");
        rd(A_ERR, 32'h30, "R9 read error");
        rd(win(3, 90), 32'h21, "R9 other bank readable");
        wr(A_ERR, 32'h30);
        rd(A_ERR, 32'h00, "R10 both cleared");
        rd_prot = 8'h00;
        ovr_prot = 8'h00;

        // R12 top corner: bank 7 row 255 bit 3
        wr(A_ADRH, 32'h3F);
        wr(A_ADRL, 32'hFB);
        wr(A_CTRL, 32'h01);
        busy_len(n);
        rd(14'h27FC, 32'h08, "R12 last row");
        rd(win(7, 254), 32'h00, "R12 neighbour row");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule